// File: doc/BRIEF.md
# Time-over-threshold trim calibrator

This block tunes the digital code that sets a pixel's leakage-compensation feedback current. For each candidate code it fires a one-cycle internal test pulse into the front-end. It then times how long the pixel discriminator stays high, counting system clock cycles. The threshold seen by the discriminator during this step is set by the global threshold DAC, outside this block.

The measured time over threshold is compared with an inclusive target window. The window is chosen so that the preamplifier baseline restores much more slowly than the shaper peaks, around 100 us at the nominal operating point. A long measurement steps the code down by one and a short one steps it up by one. A new pulse then follows. The loop ends with `done` when a measurement lands in the window. It ends with `fail` when the iteration budget is spent or when the code would have to leave its range.

The discriminator input is treated as asynchronous and passes through a parameterised synchronizer before edge detection.

Top module: `tot_trim_ctrl`

## Requirements
- R1: While reset is held, `trim_code` equals `INIT_CODE` and `test_pulse`, `done` and `fail` are low.
- R2: A `start` sampled high while the block is idle, done or failed reloads `trim_code` with `INIT_CODE` and clears `done` and `fail`. In the next cycle `test_pulse` is high for exactly one cycle. A `start` during a run in progress is ignored.
- R3: After a test pulse, a measurement begins only at a rising edge of the synchronized discriminator. Its value is the number of clock cycles the synchronized discriminator is sampled high, up to the falling edge. A discriminator that is already high when the pulse fires does not count.
- R4: The time-over-threshold counter is `TOT_W` bits wide (20 by default) and saturates at its all-ones value instead of wrapping.
- R5: If no rising edge arrives within `TIMEOUT` cycles after the test pulse, the measurement is taken as zero.
- R6: A measurement with `tot_lo <= value <= tot_hi` raises `done` with the code unchanged. `done` and the code hold until the next accepted `start`.
- R7: A measurement above `tot_hi` lowers the code by one and a measurement below `tot_lo` raises it by one, each followed by a new test pulse. The code never moves by more than one step per clock.
- R8: If the required step would take the code below 0 or above 2^`CODE_W`-1, `fail` is raised and the code keeps its value.
- R9: A run fires at most `max_iter` test pulses, with 0 treated as 1. When the last allowed measurement is outside the window and no bound is hit, `fail` is raised with the code unchanged.
- R10: `done` and `fail` are never high together. No test pulse is fired while either is high, and the code is stable while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run |
| disc | input | 1 | Discriminator output level (asynchronous) |
| tot_lo | input | TOT_W | Lower bound of target window, inclusive |
| tot_hi | input | TOT_W | Upper bound of target window, inclusive |
| max_iter | input | ITER_W | Maximum number of measurements per run (0 acts as 1) |
| trim_code | output | CODE_W | Feedback-current DAC code |
| test_pulse | output | 1 | One-cycle test-pulse strobe |
| done | output | 1 | Run ended with a measurement inside the window |
| fail | output | 1 | Run ended on the iteration limit or a code bound |

## Verification
The checker watches the sequencing rules on every cycle: the code reload and single-cycle strobe after an accepted start, the one-step limit on code movement, the pulse budget per run, and the exclusive, frozen end states. The measurement itself can only be shown by the bench's scenarios, which steer the loop through chosen discriminator widths and compare the final outcome, code and pulse count. These scenarios cover exact width counting, the edge requirement, timeout to zero, counter saturation, both code bounds, the iteration limit and a start ignored mid-run.

// File: rtl/tot_trim_pkg.sv
package tot_trim_pkg;

   // run sequencer states
   typedef enum logic [2:0] {
      CAL_IDLE   = 3'd0,
      CAL_FIRE   = 3'd1,
      CAL_LISTEN = 3'd2,
      CAL_DONE   = 3'd3,
      CAL_FAIL   = 3'd4
   } cal_state_e;

   // measurement unit states
   typedef enum logic [1:0] {
      MT_IDLE = 2'd0,
      MT_WAIT = 2'd1,
      MT_HIGH = 2'd2
   } meter_state_e;

endpackage

// File: rtl/tot_meter.sv
module tot_meter
   import tot_trim_pkg::*;
#(
   parameter int TOT_W       = 20,
   parameter int TIMEOUT     = 4096,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             disc,
   output logic             meas_valid,
   output logic [TOT_W-1:0] meas_tot
);
   localparam int               WAIT_W   = $clog2(TIMEOUT + 1);
   localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(TIMEOUT - 1);
   localparam logic [TOT_W-1:0]  TOT_MAX  = '1;

   logic ds, ds_q, rise;

   // synchronizer variant chosen by depth
   if (SYNC_STAGES == 0) begin : g_nosync
      assign ds = disc;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= (chain << 1) | SYNC_STAGES'(disc);
      end
      assign ds = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ds_q <= 1'b0;
      else        ds_q <= ds;
   end
   assign rise = ds & ~ds_q;

   meter_state_e      st_q;
   logic [WAIT_W-1:0] wait_q;
   logic [TOT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= MT_IDLE;
         wait_q     <= '0;
         cnt_q      <= '0;
         meas_valid <= 1'b0;
         meas_tot   <= '0;
      end else begin
         meas_valid <= 1'b0;
         unique case (st_q)
            MT_IDLE: begin
               if (arm) begin
                  st_q   <= MT_WAIT;
                  wait_q <= '0;
               end
            end
            MT_WAIT: begin
               if (rise) begin
                  st_q  <= MT_HIGH;
                  cnt_q <= TOT_W'(1);
               end else if (wait_q == WAIT_END) begin
                  st_q       <= MT_IDLE;
                  meas_valid <= 1'b1;
                  meas_tot   <= '0;
               end else begin
                  wait_q <= wait_q + WAIT_W'(1);
               end
            end
            MT_HIGH: begin
               if (ds) begin
                  if (cnt_q != TOT_MAX) cnt_q <= cnt_q + TOT_W'(1);
               end else begin
                  st_q       <= MT_IDLE;
                  meas_valid <= 1'b1;
                  meas_tot   <= cnt_q;
               end
            end
            default: st_q <= MT_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/trim_stepper.sv
module trim_stepper #(
   parameter int CODE_W    = 6,
   parameter int INIT_CODE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step_up,
   input  logic              step_dn,
   output logic [CODE_W-1:0] code,
   output logic              at_min,
   output logic              at_max
);
   localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(INIT_CODE);
   localparam logic [CODE_W-1:0] CODE_TOP  = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  code <= CODE_INIT;
      else if (load)               code <= CODE_INIT;
      else if (step_up && !at_max) code <= code + CODE_W'(1);
      else if (step_dn && !at_min) code <= code - CODE_W'(1);
   end

   assign at_min = (code == '0);
   assign at_max = (code == CODE_TOP);
endmodule

// File: rtl/tot_trim_ctrl.sv
module tot_trim_ctrl
   import tot_trim_pkg::*;
#(
   parameter int CODE_W      = 6,
   parameter int TOT_W       = 20,
   parameter int ITER_W      = 8,
   parameter int TIMEOUT     = 4096,
   parameter int INIT_CODE   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              disc,
   input  logic [TOT_W-1:0]  tot_lo,
   input  logic [TOT_W-1:0]  tot_hi,
   input  logic [ITER_W-1:0] max_iter,
   output logic [CODE_W-1:0] trim_code,
   output logic              test_pulse,
   output logic              done,
   output logic              fail
);
   // elaboration-time parameter checks
   if (CODE_W < 2)                          begin : g_bad_code  $error("CODE_W must be at least 2");       end
   if (TOT_W < 2)                           begin : g_bad_tot   $error("TOT_W must be at least 2");        end
   if (ITER_W < 1)                          begin : g_bad_iter  $error("ITER_W must be at least 1");       end
   if (TIMEOUT < 1)                         begin : g_bad_tmo   $error("TIMEOUT must be at least 1");      end
   if (INIT_CODE < 0 || INIT_CODE >= (1 << CODE_W)) begin : g_bad_init $error("INIT_CODE out of range"); end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4)  begin : g_bad_sync  $error("SYNC_STAGES must be 0 to 4");      end

   cal_state_e        st_q, st_d;
   logic [ITER_W-1:0] iter_q;
   logic [ITER_W:0]   iter_next;
   logic              accept, meas_valid, in_win, too_long, limit_hit;
   logic              step_up, step_dn, at_min, at_max;
   logic [TOT_W-1:0]  meas_tot;

   assign accept = start && (st_q == CAL_IDLE || st_q == CAL_DONE || st_q == CAL_FAIL);

   tot_meter #(.TOT_W(TOT_W), .TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_meter (
      .clk(clk), .rst_n(rst_n), .arm(test_pulse), .disc(disc),
      .meas_valid(meas_valid), .meas_tot(meas_tot)
   );

   trim_stepper #(.CODE_W(CODE_W), .INIT_CODE(INIT_CODE)) u_stepper (
      .clk(clk), .rst_n(rst_n), .load(accept), .step_up(step_up), .step_dn(step_dn),
      .code(trim_code), .at_min(at_min), .at_max(at_max)
   );

   assign in_win    = (meas_tot >= tot_lo) && (meas_tot <= tot_hi);
   assign too_long  = (meas_tot > tot_hi);
   assign iter_next = {1'b0, iter_q} + (ITER_W+1)'(1);
   assign limit_hit = (iter_next >= {1'b0, max_iter});

   always_comb begin
      st_d    = st_q;
      step_up = 1'b0;
      step_dn = 1'b0;
      unique case (st_q)
         CAL_IDLE, CAL_DONE, CAL_FAIL: if (accept) st_d = CAL_FIRE;
         CAL_FIRE:                     st_d = CAL_LISTEN;
         CAL_LISTEN: begin
            if (meas_valid) begin
               if (in_win)                        st_d = CAL_DONE;
               else if (too_long ? at_min : at_max) st_d = CAL_FAIL;
               else if (limit_hit)                st_d = CAL_FAIL;
               else begin
                  st_d    = CAL_FIRE;
                  step_dn = too_long;
                  step_up = !too_long;
               end
            end
         end
         default: st_d = CAL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= CAL_IDLE;
         iter_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept)                  iter_q <= '0;
         else if (step_up || step_dn) iter_q <= iter_q + ITER_W'(1);
      end
   end

   assign test_pulse = (st_q == CAL_FIRE);
   assign done       = (st_q == CAL_DONE);
   assign fail       = (st_q == CAL_FAIL);
endmodule

// File: rtl/tot_trim_checks.sv
module tot_trim_checks #(
   parameter int CODE_W    = 6,
   parameter int ITER_W    = 8,
   parameter int INIT_CODE = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_acc,
   input logic              test_pulse,
   input logic              done,
   input logic              fail,
   input logic [CODE_W-1:0] trim_code,
   input logic [ITER_W-1:0] max_iter
);
   logic [ITER_W:0] pulse_cnt;
   logic [ITER_W:0] pulse_lim;

   assign pulse_lim = (max_iter == '0) ? (ITER_W+1)'(1) : {1'b0, max_iter};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pulse_cnt <= '0;
      else if (start_acc)  pulse_cnt <= '0;
      else if (test_pulse) pulse_cnt <= pulse_cnt + (ITER_W+1)'(1);
   end

   // R2: accepted start reloads code, clears end flags and strobes once
   p_start_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc |=> (test_pulse && trim_code == CODE_W'(INIT_CODE) && !done && !fail));
   p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      test_pulse |=> !test_pulse);

   // R7: code moves by at most one step per clock outside a reload
   p_one_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start_acc) |-> (trim_code == $past(trim_code) ||
                             trim_code == $past(trim_code) + CODE_W'(1) ||
                             trim_code == $past(trim_code) - CODE_W'(1)));

   // R9: pulse budget per run
   p_pulse_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
      test_pulse |-> (pulse_cnt < pulse_lim));

   // R10: exclusive, quiet and frozen end states
   p_exclusive_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
   p_quiet_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> !test_pulse);
   p_frozen_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((done || fail) && !start_acc) |=> ($stable(trim_code) && $stable(done) && $stable(fail)));

   // R6: done holds until a start is accepted
   p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_acc) |=> done);
endmodule

bind tot_trim_ctrl tot_trim_checks #(
   .CODE_W(CODE_W), .ITER_W(ITER_W), .INIT_CODE(INIT_CODE)
) u_checks (
   .clk(clk), .rst_n(rst_n), .start_acc(accept), .test_pulse(test_pulse),
   .done(done), .fail(fail), .trim_code(trim_code), .max_iter(max_iter)
);

// File: tb/tot_trim_ctrl_bench.sv
module tot_trim_ctrl_bench;
   localparam int CODE_W = 4;
   localparam int TOT_W  = 10;
   localparam int ITER_W = 6;
   localparam int TMO    = 64;
   localparam int INIT   = 8;

   logic              clk = 1'b0;
   logic              rst_n, start, disc;
   logic [TOT_W-1:0]  tot_lo, tot_hi;
   logic [ITER_W-1:0] max_iter;
   logic [CODE_W-1:0] trim_code;
   logic              test_pulse, done, fail;

   always #2 clk = ~clk;

   tot_trim_ctrl #(
      .CODE_W(CODE_W), .TOT_W(TOT_W), .ITER_W(ITER_W),
      .TIMEOUT(TMO), .INIT_CODE(INIT), .SYNC_STAGES(2)
   ) u_tot_trim_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .disc(disc),
      .tot_lo(tot_lo), .tot_hi(tot_hi), .max_iter(max_iter),
      .trim_code(trim_code), .test_pulse(test_pulse), .done(done), .fail(fail)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   int    resp_q[$];
   int    exp_out_q[$];
   int    exp_code_q[$];
   int    exp_pul_q[$];
   string exp_tag_q[$];
   int    mon_pulses = 0;
   bit    mon_prev_end = 1'b0;

   task automatic check_eq(input string req, input string what, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // discriminator model: >0 width in cycles, 0 silent, <0 release a held level
   initial begin
      disc = 1'b0;
      forever begin
         @(negedge clk);
         if (test_pulse && resp_q.size() > 0) begin
            int w;
            w = resp_q.pop_front();
            if (w > 0) begin
               repeat (3) @(negedge clk);
               disc = 1'b1;
               repeat (w) @(negedge clk);
               disc = 1'b0;
            end else if (w < 0) begin
               repeat (40) @(negedge clk);
               disc = 1'b0;
            end
         end
      end
   end

   // monitor: pops expected outcome when a run ends
   initial begin
      forever begin
         @(negedge clk);
         if (test_pulse) mon_pulses++;
         if ((done || fail) && !mon_prev_end) begin
            if (exp_out_q.size() == 0) begin
               check_eq("R6", "unexpected end of run", 1, 0);
            end else begin
               string t;
               t = exp_tag_q.pop_front();
               check_eq(t, "outcome (1=done 2=fail)", done ? 1 : 2, exp_out_q.pop_front());
               check_eq(t, "final code", int'(trim_code), exp_code_q.pop_front());
               check_eq(t, "test pulses", mon_pulses, exp_pul_q.pop_front());
            end
            mon_pulses = 0;
         end
         mon_prev_end = done || fail;
      end
   end

   task automatic run_case(input int lo, input int hi, input int mit, input bit poke,
                           input int eo, input int ec, input int ep, input string tag);
      int c0;
      int d0;
      tot_lo   = TOT_W'(lo);
      tot_hi   = TOT_W'(hi);
      max_iter = ITER_W'(mit);
      exp_out_q.push_back(eo);
      exp_code_q.push_back(ec);
      exp_pul_q.push_back(ep);
      exp_tag_q.push_back(tag);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check_eq("R2", "strobe after start", int'(test_pulse), 1);
      check_eq("R2", "code reload", int'(trim_code), INIT);
      check_eq("R2", "flags cleared", int'(done | fail), 0);
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      while (!(done || fail)) @(negedge clk);
      c0 = int'(trim_code);
      d0 = int'(done);
      repeat (12) @(negedge clk);
      check_eq("R10", "code frozen at end", int'(trim_code), c0);
      check_eq("R6", "end flag held", int'(done), d0);
      check_eq("R10", "no strobe at end", int'(test_pulse), 0);
      check_eq(tag, "responses consumed", resp_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 watchdog: actual no completion expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      start    = 1'b0;
      tot_lo   = '0;
      tot_hi   = '0;
      max_iter = ITER_W'(20);
      repeat (3) @(negedge clk);
      check_eq("R1", "reset code", int'(trim_code), INIT);
      check_eq("R1", "reset strobe/done/fail", int'({test_pulse, done, fail}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: exact width inside window
      resp_q = '{7};
      run_case(7, 7, 20, 1'b0, 1, 8, 1, "R3");
      // R7: short then exact -> one step up
      resp_q = '{6, 7};
      run_case(7, 7, 20, 1'b0, 1, 9, 2, "R7");
      // R7: long twice then exact -> two steps down
      resp_q = '{8, 8, 7};
      run_case(7, 7, 20, 1'b0, 1, 6, 3, "R7");
      // R5: silent discriminator reads as zero
      resp_q = '{0, 4};
      run_case(3, 5, 20, 1'b0, 1, 9, 2, "R5");
      // R3: level already high at the pulse does not count
      disc = 1'b1;
      repeat (5) @(negedge clk);
      resp_q = '{-1, 5};
      run_case(5, 5, 20, 1'b0, 1, 9, 2, "R3");
      // R4: saturation at all ones
      resp_q = '{1100};
      run_case(1023, 1023, 20, 1'b0, 1, 8, 1, "R4");
      // R9: iteration limit, code left as stepped
      resp_q = '{5, 5, 5};
      run_case(50, 50, 3, 1'b0, 2, 10, 3, "R9");
      // R9: zero budget acts as one
      resp_q = '{5};
      run_case(50, 50, 0, 1'b0, 2, 8, 1, "R9");
      // R8: upper code bound
      resp_q = '{5, 5, 5, 5, 5, 5, 5, 5};
      run_case(50, 50, 20, 1'b0, 2, 15, 8, "R8");
      // R8: lower code bound
      resp_q = '{60, 60, 60, 60, 60, 60, 60, 60, 60};
      run_case(50, 50, 20, 1'b0, 2, 0, 9, "R8");
      // R2: start during a run is ignored
      resp_q = '{20, 7};
      run_case(7, 7, 20, 1'b1, 1, 7, 2, "R2");

      check_eq("R6", "pending expectations", exp_out_q.size(), 0);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule